// File: doc/BRIEF.md
# Buffered Omega Switching Fabric

This block connects N source ports to N sink ports, N a power of two, through log2(N) stages of 2x2 switching elements. Each stage has N/2 elements. Lines are joined by a perfect shuffle, so a line index is rotated left by one bit before every stage, including the first. A message holds a broadcast flag, a destination index and a payload. It moves forward one stage per clock edge. Each element is set straight, crossed, upper-broadcast or lower-broadcast by the messages on its inputs. At stage k the element routes on destination bit log2(N)-1-k: a 0 goes to the upper output and a 1 goes to the lower output.

Each element output has a first-in first-out queue of Q_DEPTH entries. When both inputs of an element need the same output in one clock, the upper input is queued first. The lower input is queued behind it if there is room, and otherwise waits where it is. A message that is already queued always leaves before a newer arrival. A queue that is full removes ready from the line that feeds it, so the source stalls and no message is lost. The sink side has no ready signal, and the final queues drain one message per output per clock. Source ports use a valid/ready handshake.

Top module: `omega_qnet`

## Requirements
- R1: After reset, every bit of out_valid is 0 and every bit of in_ready is 1.
- R2: A unicast message on port p uses in_dest[p*log2N +: log2N] and in_data[p*DATA_W +: DATA_W]. It leaves exactly once, on output d = its destination, with out_data[d*DATA_W +: DATA_W] equal to the payload it entered with. For every permutation in a test set, each message reaches its destination with no loss and no copy.
- R3: On an idle network, a message accepted at clock edge t raises out_valid at its destination right after edge t+log2(N)-1, for exactly one cycle.
- R4: Suppose the upper and lower inputs of one element both want the same output in one cycle, and the queue is empty. The upper input's message leaves first, and the lower one leaves one cycle later.
- R5: A message with in_bcast=1 ignores its destination and reaches every output exactly once. On an idle network, all copies appear in the same cycle, R3 cycles after acceptance.
- R6: Each element output queue holds at most Q_DEPTH (default 2) messages. A full queue that is not draining takes no new message. Under a hot spot, in_ready falls, and every message is still delivered exactly once.
- R7: Messages from one source to one destination arrive in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N_PORTS | A message is offered on the source port |
| in_ready | output | N_PORTS | The source port takes its message at the next edge |
| in_bcast | input | N_PORTS | Copy the message to every output |
| in_dest | input | N_PORTS*log2(N_PORTS) | Destination index per port, packed by port |
| in_data | input | N_PORTS*DATA_W | Payload per port, packed by port |
| out_valid | output | N_PORTS | A message is present at the sink port this cycle |
| out_data | output | N_PORTS*DATA_W | Payload per sink port, packed by port |

## Verification
The hand-built cases drive one handshake and then check out_valid at each falling edge that follows. Zero is expected through edge t+log2(N)-2. The message is expected right after edge t+log2(N)-1, and zero again one cycle later. This covers a single unicast, a broadcast and an upper/lower conflict, where the second message is due one edge after the first. Burst tests do not depend on exact timing. They record ready at the falling edge before each accepting edge, let the fabric drain for a fixed window, and then count arrivals per output and tag against the expected destination mask.

// File: rtl/omega_qnet.sv
module omega_qnet #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 12,
  parameter int Q_DEPTH = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_PORTS-1:0]                   in_valid,
  output logic [N_PORTS-1:0]                   in_ready,
  input  logic [N_PORTS-1:0]                   in_bcast,
  input  logic [N_PORTS*$clog2(N_PORTS)-1:0]   in_dest,
  input  logic [N_PORTS*DATA_W-1:0]            in_data,
  output logic [N_PORTS-1:0]                   out_valid,
  output logic [N_PORTS*DATA_W-1:0]            out_data
);
  localparam int STAGES = $clog2(N_PORTS);
  localparam int DW     = STAGES;
  localparam int MW     = 1 + DW + DATA_W;
  localparam int CW     = $clog2(Q_DEPTH + 1);

  // message layout: {bcast, dest, payload}
  logic [N_PORTS-1:0] src_v   [STAGES];
  logic [MW-1:0]      src_m   [STAGES][N_PORTS];
  logic [N_PORTS-1:0] src_rdy [STAGES];
  logic [N_PORTS-1:0] hd_v    [STAGES];
  logic [MW-1:0]      hd_m    [STAGES][N_PORTS];
  logic [N_PORTS-1:0] hd_pop  [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar j = 0; j < N_PORTS; j++) begin : g_link
      localparam int U = (j >> 1) | ((j & 1) << (STAGES - 1));
      if (s == 0) begin : g_in
        assign src_v[0][j]  = in_valid[U];
        assign src_m[0][j]  = {in_bcast[U], in_dest[U*DW +: DW], in_data[U*DATA_W +: DATA_W]};
        assign in_ready[U]  = src_rdy[0][j];
      end else begin : g_mid
        assign src_v[s][j]     = hd_v[s-1][U];
        assign src_m[s][j]     = hd_m[s-1][U];
        assign hd_pop[s-1][U]  = hd_v[s-1][U] & src_rdy[s][j];
      end
    end

    for (genvar e = 0; e < N_PORTS/2; e++) begin : g_elem
      localparam int RB = STAGES - 1 - s;
      logic [1:0]    wu, wl, rdy, pa, pb;
      logic [CW-1:0] cnt_o [2];

      for (genvar i = 0; i < 2; i++) begin : g_want
        logic [MW-1:0] m;
        assign m     = src_m[s][2*e+i];
        assign wu[i] = src_v[s][2*e+i] & (m[MW-1] | ~m[DATA_W+RB]);
        assign wl[i] = src_v[s][2*e+i] & (m[MW-1] |  m[DATA_W+RB]);
      end

      assign rdy[0] = (~wu[0] | (int'(cnt_o[0]) < Q_DEPTH)) &
                      (~wl[0] | (int'(cnt_o[1]) < Q_DEPTH));
      assign pa     = {wl[0], wu[0]} & {2{rdy[0]}};
      assign rdy[1] = (~wu[1] | (int'(cnt_o[0]) + int'(pa[0]) < Q_DEPTH)) &
                      (~wl[1] | (int'(cnt_o[1]) + int'(pa[1]) < Q_DEPTH));
      assign pb     = {wl[1], wu[1]} & {2{rdy[1]}};
      assign src_rdy[s][2*e]   = rdy[0];
      assign src_rdy[s][2*e+1] = rdy[1];

      for (genvar o = 0; o < 2; o++) begin : g_q
        localparam int L = 2*e + o;
        logic [MW-1:0] mem [Q_DEPTH];
        logic [CW-1:0] cnt, base;

        assign cnt_o[o] = cnt;
        assign base     = cnt - CW'(hd_pop[s][L]);

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) cnt <= '0;
          else        cnt <= base + CW'(pa[o]) + CW'(pb[o]);
        end

        always_ff @(posedge clk) begin
          for (int i = 0; i < Q_DEPTH; i++) begin
            if (hd_pop[s][L] && i < Q_DEPTH-1) mem[i] <= mem[(i+1) % Q_DEPTH];
            if (pa[o] && CW'(i) == base) mem[i] <= src_m[s][2*e];
            if (pb[o] && CW'(i) == base + CW'(pa[o])) mem[i] <= src_m[s][2*e+1];
          end
        end

        assign hd_v[s][L] = (cnt != '0);
        assign hd_m[s][L] = mem[0];

        a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
          int'(cnt) <= Q_DEPTH);
        a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
          (int'(cnt) == Q_DEPTH && !hd_pop[s][L]) |=> int'(cnt) == Q_DEPTH);

        if (s == STAGES-1) begin : g_chk
          a_r2_dest_match: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt != '0 && !mem[0][MW-1]) |-> mem[0][DATA_W +: DW] == DW'(L));
        end
      end
    end
  end

  assign hd_pop[STAGES-1] = hd_v[STAGES-1];
  assign out_valid        = hd_v[STAGES-1];

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out
    assign out_data[j*DATA_W +: DATA_W] = hd_m[STAGES-1][j][DATA_W-1:0];
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> out_valid == '0);

endmodule

// File: tb/omega_qnet_tb.sv
module omega_qnet_tb_top;
  localparam int N = 8, LG = 3, DW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]    in_valid, in_ready, in_bcast, out_valid;
  logic [N*LG-1:0] in_dest;
  logic [N*DW-1:0] in_data, out_data;

  omega_qnet #(.N_PORTS(N), .DATA_W(DW), .Q_DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bcast(in_bcast), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int pq_n[N], pq_rd[N], p_dst[N][8];
  bit p_bc[N][8];
  bit [N-1:0] expm[64];
  bit used[64];
  int got[N][64], lastk[N][N];
  bit mon_en = 0, ord_en = 0, saw_stall = 0;
  logic [DW-1:0] md;
  int tg_m;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    for (int o = 0; o < N; o++) if (out_valid[o]) begin
      md   = out_data[o*DW +: DW];
      tg_m = int'(md[5:0]);
      if (md[11:6] != ~md[5:0]) chk(0, "R2", "payload intact", int'(md[11:6]), int'(~md[5:0]));
      got[o][tg_m]++;
      if (ord_en) begin
        if (tg_m % 8 <= lastk[o][tg_m/8]) chk(0, "R7", "source order", tg_m % 8, lastk[o][tg_m/8] + 1);
        lastk[o][tg_m/8] = tg_m % 8;
      end
    end
  end

  task automatic clear();
    for (int p = 0; p < N; p++) begin
      pq_n[p] = 0;
      for (int q = 0; q < N; q++) lastk[p][q] = -1;
      for (int t = 0; t < 64; t++) got[p][t] = 0;
    end
    for (int t = 0; t < 64; t++) used[t] = 0;
    saw_stall = 0;
  endtask

  task automatic add(input int p, input int dst, input bit bc);
    int k, t;
    k = pq_n[p]; t = p*8 + k;
    p_dst[p][k] = dst; p_bc[p][k] = bc;
    used[t] = 1;
    expm[t] = bc ? '1 : N'(1 << dst);
    pq_n[p]++;
  endtask

  task automatic run_burst(input string req, input bit ord);
    int guard, t, first_act, first_exp;
    bit busy, ok;
    bit [N-1:0] acc;
    ord_en = ord; mon_en = 1; guard = 0; busy = 1;
    for (int p = 0; p < N; p++) pq_rd[p] = 0;
    while (busy && guard < 3000) begin
      @(negedge clk);
      for (int p = 0; p < N; p++) begin
        if (pq_rd[p] < pq_n[p]) begin
          t = p*8 + pq_rd[p];
          in_valid[p] = 1'b1;
          in_bcast[p] = p_bc[p][pq_rd[p]];
          in_dest[p*LG +: LG] = LG'(p_dst[p][pq_rd[p]]);
          in_data[p*DW +: DW] = {~6'(t), 6'(t)};
        end else in_valid[p] = 1'b0;
      end
      #1;
      acc = in_valid & in_ready;
      if ((in_valid & ~in_ready) != '0) saw_stall = 1;
      @(posedge clk);
      busy = 0;
      for (int p = 0; p < N; p++) begin
        if (acc[p]) pq_rd[p]++;
        if (pq_rd[p] < pq_n[p]) busy = 1;
      end
      guard++;
    end
    @(negedge clk); in_valid = '0;
    repeat (80) @(negedge clk);
    ok = (guard < 3000); first_act = 0; first_exp = 0;
    for (int tt = 0; tt < 64; tt++)
      for (int o = 0; o < N; o++)
        if (got[o][tt] != ((used[tt] && expm[tt][o]) ? 1 : 0)) begin
          if (ok) begin first_act = got[o][tt]; first_exp = (used[tt] && expm[tt][o]) ? 1 : 0; end
          ok = 0;
        end
    chk(ok, req, "exactly-once delivery", first_act, first_exp);
    mon_en = 0;
  endtask

  initial begin
    #(8*150000);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int perm[N];
    int j, tmp, nm;
    bit any;
    in_valid = '0; in_bcast = '0; in_dest = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '1, "R1", "in_ready after reset", int'(in_ready), 255);

    // R3: single unicast, port 2 -> output 6
    in_valid[2] = 1'b1; in_dest[2*LG +: LG] = 3'd6; in_data[2*DW +: DW] = 12'h5A3;
    #1 chk(in_ready[2], "R3", "ready on idle", int'(in_ready[2]), 1);
    @(posedge clk); @(negedge clk); in_valid = '0;
    chk(out_valid == '0, "R3", "not yet after accept edge", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == '0, "R3", "not yet after one more edge", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 8'h40, "R3", "arrival at output 6", int'(out_valid), 64);
    chk(out_data[6*DW +: DW] == 12'h5A3, "R2", "payload at output 6", int'(out_data[6*DW +: DW]), 12'h5A3);
    @(negedge clk);
    chk(out_valid == '0, "R3", "single-cycle presence", int'(out_valid), 0);

    // R5: broadcast from port 3
    in_valid[3] = 1'b1; in_bcast[3] = 1'b1; in_dest[3*LG +: LG] = 3'd2; in_data[3*DW +: DW] = 12'h3C7;
    @(posedge clk); @(negedge clk); in_valid = '0; in_bcast = '0;
    chk(out_valid == '0, "R5", "broadcast not early", int'(out_valid), 0);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == '1, "R5", "broadcast on all outputs together", int'(out_valid), 255);
    any = 0;
    for (int o = 0; o < N; o++) if (out_data[o*DW +: DW] != 12'h3C7) any = 1;
    chk(!any, "R5", "broadcast payload on all outputs", int'(any), 0);
    @(negedge clk);
    chk(out_valid == '0, "R5", "broadcast copied once", int'(out_valid), 0);

    // R4: ports 0 and 4 meet at stage 0 element 0, both want upper
    in_valid[0] = 1'b1; in_dest[0 +: LG] = 3'd0; in_data[0 +: DW] = 12'h111;
    in_valid[4] = 1'b1; in_dest[4*LG +: LG] = 3'd1; in_data[4*DW +: DW] = 12'h222;
    #1 chk(in_ready[0] && in_ready[4], "R4", "both queued when empty", int'({in_ready[4], in_ready[0]}), 3);
    @(posedge clk); @(negedge clk); in_valid = '0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 8'h01, "R4", "upper input first", int'(out_valid), 1);
    @(negedge clk);
    chk(out_valid == 8'h02, "R4", "lower input one cycle later", int'(out_valid), 2);
    chk(out_data[1*DW +: DW] == 12'h222, "R2", "payload at output 1", int'(out_data[1*DW +: DW]), 12'h222);
    repeat (4) @(negedge clk);

    // R2: permutation set
    clear(); for (int p = 0; p < N; p++) add(p, p, 0); run_burst("R2", 0);
    clear(); for (int p = 0; p < N; p++) add(p, ((p & 1) << 2) | (p & 2) | ((p >> 2) & 1), 0); run_burst("R2", 0);
    for (int sh = 1; sh < N; sh++) begin
      clear(); for (int p = 0; p < N; p++) add(p, (p + sh) % N, 0); run_burst("R2", 0);
    end
    for (int x = 1; x < N; x++) begin
      clear(); for (int p = 0; p < N; p++) add(p, p ^ x, 0); run_burst("R2", 0);
    end
    for (int r = 0; r < 10; r++) begin
      for (int i = 0; i < N; i++) perm[i] = i;
      for (int i = N-1; i > 0; i--) begin
        j = $urandom_range(i, 0); tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
      end
      clear(); for (int p = 0; p < N; p++) add(p, perm[p], 0); run_burst("R2", 0);
    end

    // R5 with unicast: random mixed traffic
    for (int r = 0; r < 10; r++) begin
      clear();
      for (int p = 0; p < N; p++) begin
        nm = $urandom_range(8, 1);
        for (int k = 0; k < nm; k++) add(p, $urandom_range(N-1, 0), ($urandom_range(7, 0) == 0));
      end
      run_burst("R5", 0);
    end

    // R6 and R7: hot spot on output 5
    clear();
    for (int p = 0; p < N; p++) for (int k = 0; k < 8; k++) add(p, 5, 0);
    run_burst("R6", 1);
    chk(saw_stall, "R6", "in_ready dropped under hot spot", int'(saw_stall), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule